// File: doc/BRIEF.md
# Ring Bus Memory Copier

This block is a one-way packet ring. A controller injects packets at the head of the ring. The packets pass through a chain of memory-holding stages, one register per stage, and come back from the last stage to the controller. Each stage owns a slice of the address space and keeps a small local word memory.

A write packet is applied by its owning stage. It then keeps travelling to the end of the ring, where the controller drops it. A read packet is turned by its owning stage into a read-data packet that carries the stored word back to the controller.

A block copy is carried out entirely over the ring. The controller first issues a burst of reads over the source range and collects the returning data in a FIFO. It then pops that data and sends it back down the ring as writes to the destination range. The copy counts as finished only once every one of those writes has come back and been dropped.

The host side offers three commands, taken one at a time: a single write, a single read (peek) and a block copy.

Top module: `ring_copy_top`

## Requirements
- R1: The owning stage of an address is addr[15:14] and the word within it is addr[3:0]. A write command stores cmd_data at that word, and a later peek of the same address returns it.
- R2: A stage forwards a packet it does not own unchanged, one cycle after receiving it.
- R3: An owned read packet leaves its stage one cycle later as a read-data packet (opcode 3) with the same address and the stored word in its data field.
- R4: Every packet that returns from the last stage is consumed by the controller and never re-enters the ring. Once no command is active, the ring is empty.
- R5: A peek (cmd_kind 2) raises rd_valid for exactly one cycle with the stored word on rd_data. done pulses for one cycle when any command has completed.
- R6: A copy (cmd_kind 3) with source cmd_src, destination cmd_addr and length n issues all n reads before any write. Read data returns in source-address order. Afterwards, destination word dst+i holds the value that source word src+i held when the copy started, so overlapping ranges copy from a snapshot.
- R7: A copy of length 0 completes with a done pulse and changes no memory. A length above MAX_LEN (16) is treated as MAX_LEN.
- R8: cmd_ready is high only while the controller is idle. A command presented while cmd_ready is low, or with cmd_kind 0, is ignored.
- R9: Source and destination addresses advance modulo 2^16.
- R10: After reset, cmd_ready is 1, rd_valid and done are 0, and every memory word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_kind | input | 2 | 0 none, 1 write, 2 peek, 3 copy |
| cmd_addr | input | 16 | Write/peek address, or copy destination base |
| cmd_src | input | 16 | Copy source base |
| cmd_len | input | 6 | Copy length in words |
| cmd_data | input | 32 | Write data |
| cmd_ready | output | 1 | Controller idle, command accepted this cycle if valid |
| rd_valid | output | 1 | Peek data valid (one cycle) |
| rd_data | output | 32 | Peek data |
| done | output | 1 | One-cycle pulse when a command completes |

## Verification
The bench aims at the cases where ring ordering matters. One is an overlapping copy whose destination lies inside its source: a design that interleaved writes with reads would copy already-overwritten words. Another is a copy that runs past address 0xFFFF into stage 0: a design that did not wrap would write the wrong stage. Further cases are zero-length and over-long copies, where a design that got them wrong would hang or overflow its FIFO, and commands sent while the controller is busy, which a broken handshake would wrongly apply. Random copies between random ranges are followed by a full readback of every word against a bench model.

// File: rtl/ring_pkg.sv
package ring_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_RDATA = 2'd3
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } pkt_t;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_PEEK  = 2'd2,
        CMD_COPY  = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ONE,
        ST_ONE_WAIT,
        ST_RD,
        ST_RD_WAIT,
        ST_WR,
        ST_WR_WAIT
    } ctrl_st_e;

    // owning stage index taken from the top sel_w address bits
    function automatic int unsigned stage_sel(input logic [ADDR_W-1:0] a, input int sel_w);
        logic [ADDR_W-1:0] s;
        s = a >> (ADDR_W - sel_w);
        return int'(s);
    endfunction

endpackage

// File: rtl/ring_stage.sv
module ring_stage
    import ring_pkg::*;
#(
    parameter int STAGE_ID = 0,
    parameter int STAGES   = 4,
    parameter int WORDS    = 16
) (
    input  logic clk,
    input  logic rst,
    input  pkt_t pkt_in,
    output pkt_t pkt_out
);
    localparam int SEL_W = $clog2(STAGES);
    localparam int LOC_W = $clog2(WORDS);

    logic [DATA_W-1:0] mem [WORDS];
    logic              owned;
    logic [LOC_W-1:0]  loc;

    assign owned = (stage_sel(pkt_in.addr, SEL_W) == STAGE_ID);
    assign loc   = pkt_in.addr[LOC_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_out <= '0;
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else begin
            pkt_out <= pkt_in;
            if (owned && pkt_in.op == OP_WRITE) begin
                mem[loc] <= pkt_in.data;
            end
            if (owned && pkt_in.op == OP_READ) begin
                pkt_out.op   <= OP_RDATA;
                pkt_out.data <= mem[loc];
            end
        end
    end
endmodule

// File: rtl/ring_fifo.sv
module ring_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign dout = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else begin
            if (push) begin
                store[wr_ptr] <= din;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
        end
    end
endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl
    import ring_pkg::*;
#(
    parameter int STAGES  = 4,
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ADDR_W-1:0] cmd_src,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [DATA_W-1:0] cmd_data,
    input  pkt_t              ret,
    input  logic [DATA_W-1:0] fifo_dout,
    output pkt_t              inj,
    output logic              fifo_push,
    output logic              fifo_pop,
    output logic              cmd_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    localparam int IF_W = $clog2(MAX_LEN + STAGES + 2);

    ctrl_st_e          state;
    cmd_e              kind_q;
    logic [ADDR_W-1:0] dst_q, src_q;
    logic [DATA_W-1:0] data_q;
    logic [LEN_W-1:0]  len_q, idx;
    logic [IF_W-1:0]   inflight;
    logic [LEN_W-1:0]  len_eff;
    logic [ADDR_W-1:0] idx_ext;
    logic              accept, inj_live, ret_live, last_idx;

    assign cmd_ready = (state == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready && (cmd_e'(cmd_kind) != CMD_NONE);
    assign len_eff   = (cmd_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : cmd_len;
    assign idx_ext   = {{(ADDR_W-LEN_W){1'b0}}, idx};
    assign last_idx  = (idx == len_q - LEN_W'(1));

    always_comb begin
        inj = '0;
        unique case (state)
            ST_ONE: begin
                inj.op   = (kind_q == CMD_WRITE) ? OP_WRITE : OP_READ;
                inj.addr = dst_q;
                inj.data = data_q;
            end
            ST_RD: begin
                inj.op   = OP_READ;
                inj.addr = src_q + idx_ext;
            end
            ST_WR: begin
                inj.op   = OP_WRITE;
                inj.addr = dst_q + idx_ext;
                inj.data = fifo_dout;
            end
            default: inj = '0;
        endcase
    end

    assign inj_live  = (inj.op != OP_NOP);
    assign ret_live  = (ret.op != OP_NOP);
    assign fifo_push = (ret.op == OP_RDATA) && (state == ST_RD || state == ST_RD_WAIT);
    assign fifo_pop  = (state == ST_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            kind_q   <= CMD_NONE;
            dst_q    <= '0;
            src_q    <= '0;
            data_q   <= '0;
            len_q    <= '0;
            idx      <= '0;
            inflight <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            done     <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            done     <= 1'b0;
            inflight <= inflight + IF_W'(inj_live) - IF_W'(ret_live);
            unique case (state)
                ST_IDLE: if (accept) begin
                    kind_q <= cmd_e'(cmd_kind);
                    dst_q  <= cmd_addr;
                    src_q  <= cmd_src;
                    data_q <= cmd_data;
                    len_q  <= len_eff;
                    idx    <= '0;
                    if (cmd_e'(cmd_kind) == CMD_COPY)
                        state <= (len_eff == '0) ? ST_WR_WAIT : ST_RD;
                    else
                        state <= ST_ONE;
                end
                ST_ONE: state <= ST_ONE_WAIT;
                ST_ONE_WAIT: begin
                    if (ret.op == OP_RDATA && kind_q == CMD_PEEK) begin
                        rd_valid <= 1'b1;
                        rd_data  <= ret.data;
                    end
                    if (inflight == '0) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                ST_RD: begin
                    idx <= idx + LEN_W'(1);
                    if (last_idx) begin
                        idx   <= '0;
                        state <= ST_RD_WAIT;
                    end
                end
                ST_RD_WAIT: if (inflight == '0) state <= ST_WR;
                ST_WR: begin
                    idx <= idx + LEN_W'(1);
                    if (last_idx) state <= ST_WR_WAIT;
                end
                ST_WR_WAIT: if (inflight == '0) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ring_copy_top.sv
module ring_copy_top
    import ring_pkg::*;
#(
    parameter int STAGES  = 4,
    parameter int WORDS   = 16,
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN) + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic [15:0]       cmd_addr,
    input  logic [15:0]       cmd_src,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [31:0]       cmd_data,
    output logic              cmd_ready,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              done
);
    // ring[0] is the injected packet, ring[k+1] leaves stage k
    pkt_t [STAGES:0]   ring;
    logic              fifo_push, fifo_pop;
    logic [DATA_W-1:0] fifo_dout;

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            ring_stage #(
                .STAGE_ID(k), .STAGES(STAGES), .WORDS(WORDS)
            ) u_stage (
                .clk(clk), .rst(rst), .pkt_in(ring[k]), .pkt_out(ring[k+1])
            );
        end
    endgenerate

    ring_fifo #(.DEPTH(MAX_LEN), .W(DATA_W)) u_fifo (
        .clk(clk), .rst(rst),
        .push(fifo_push), .din(ring[STAGES].data),
        .pop(fifo_pop), .dout(fifo_dout)
    );

    ring_ctrl #(.STAGES(STAGES), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
        .cmd_src(cmd_src), .cmd_len(cmd_len), .cmd_data(cmd_data),
        .ret(ring[STAGES]), .fifo_dout(fifo_dout), .inj(ring[0]),
        .fifo_push(fifo_push), .fifo_pop(fifo_pop),
        .cmd_ready(cmd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
    );
endmodule

// File: rtl/ring_copy_chk.sv
module ring_copy_chk
    import ring_pkg::*;
#(
    parameter int STAGES = 4
) (
    input logic            clk,
    input logic            rst,
    input pkt_t [STAGES:0] ring,
    input logic            cmd_valid,
    input logic [1:0]      cmd_kind,
    input logic [15:0]     cmd_src,
    input logic            cmd_ready,
    input logic            rd_valid,
    input logic            done
);
    localparam int SEL_W = $clog2(STAGES);

    logic        copying;
    logic [15:0] exp_src;

    always_ff @(posedge clk) begin
        if (rst) begin
            copying <= 1'b0;
            exp_src <= '0;
        end else begin
            if (cmd_valid && cmd_ready && cmd_kind == 2'd3) begin
                copying <= 1'b1;
                exp_src <= cmd_src;
            end else begin
                if (done) copying <= 1'b0;
                if (ring[STAGES].op == OP_RDATA) exp_src <= exp_src + 16'd1;
            end
        end
    end

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_chk
            // R2: non-owned packets pass through unchanged
            a_r2_forward: assert property (@(posedge clk) disable iff (rst)
                (stage_sel(ring[k].addr, SEL_W) != k) |=> (ring[k+1] == $past(ring[k])));
            // R3: owned read becomes read-data at same address
            a_r3_read_fill: assert property (@(posedge clk) disable iff (rst)
                (stage_sel(ring[k].addr, SEL_W) == k && ring[k].op == OP_READ)
                |=> (ring[k+1].op == OP_RDATA && ring[k+1].addr == $past(ring[k].addr)));
            // R4: owned writes keep travelling to the ring end
            a_r4_write_pass: assert property (@(posedge clk) disable iff (rst)
                (stage_sel(ring[k].addr, SEL_W) == k && ring[k].op == OP_WRITE)
                |=> (ring[k+1] == $past(ring[k])));
        end
    endgenerate

    // R6: copy read data returns in source order
    a_r6_rdata_order: assert property (@(posedge clk) disable iff (rst)
        (copying && ring[STAGES].op == OP_RDATA) |-> (ring[STAGES].addr == exp_src));

    // R4 / R8: idle controller sees an empty ring
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (ring[0].op == OP_NOP && ring[STAGES].op == OP_NOP));

    // R5: single-cycle pulses
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r5_rd_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
endmodule

bind ring_copy_top ring_copy_chk #(.STAGES(STAGES)) u_chk (
    .clk(clk), .rst(rst), .ring(ring), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_src(cmd_src), .cmd_ready(cmd_ready), .rd_valid(rd_valid), .done(done)
);

// File: tb/ring_copy_top_tb.sv
`timescale 1ns/1ps
module ring_copy_top_tb;
    localparam int STAGES = 4, WORDS = 16, MAX_LEN = 16, LEN_W = 6;
    localparam int NW = STAGES * WORDS;

    logic        clk = 1'b0, rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = 2'd0;
    logic [15:0] cmd_addr = '0, cmd_src = '0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic [31:0] cmd_data = '0;
    logic        cmd_ready, rd_valid, done;
    logic [31:0] rd_data;

    int total = 0, bad = 0;
    logic [31:0] model [NW];

    always #4 clk = ~clk;

    ring_copy_top u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_src(cmd_src), .cmd_len(cmd_len), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
    );

    function automatic int widx(input logic [15:0] a);
        return int'(a[15:14]) * WORDS + int'(a[3:0]);
    endfunction

    function automatic logic [15:0] waddr(input int i);
        return {i[5:4], 10'd0, i[3:0]};
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] kind, input logic [15:0] a, input logic [15:0] s,
                        input logic [LEN_W-1:0] n, input logic [31:0] d);
        int t = 0;
        @(negedge clk);
        while (!cmd_ready && t < 1000) begin @(negedge clk); t++; end
        cmd_valid = 1'b1; cmd_kind = kind; cmd_addr = a; cmd_src = s; cmd_len = n; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_kind = 2'd0;
    endtask

    task automatic wait_done(output logic seen_rd, output logic [31:0] got);
        int t = 0;
        seen_rd = 1'b0; got = '0;
        while (!done && t < 2000) begin
            if (rd_valid) begin seen_rd = 1'b1; got = rd_data; end
            @(negedge clk); t++;
        end
        check(done, "R5 done", 32'(done), 32'd1);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [31:0] d);
        logic s; logic [31:0] g;
        send(2'd1, a, 16'd0, '0, d);
        wait_done(s, g);
        model[widx(a)] = d;
    endtask

    task automatic peek_chk(input logic [15:0] a, input string req);
        logic s; logic [31:0] g;
        send(2'd2, a, 16'd0, '0, 32'd0);
        wait_done(s, g);
        check(s, "R5 rd_valid", 32'(s), 32'd1);
        check(g == model[widx(a)], req, g, model[widx(a)]);
    endtask

    task automatic model_copy(input logic [15:0] d, input logic [15:0] s, input int n);
        logic [31:0] tmp [MAX_LEN];
        int m = (n > MAX_LEN) ? MAX_LEN : n;
        for (int i = 0; i < m; i++) tmp[i] = model[widx(s + 16'(i))];
        for (int i = 0; i < m; i++) model[widx(d + 16'(i))] = tmp[i];
    endtask

    task automatic do_copy(input logic [15:0] d, input logic [15:0] s, input int n);
        logic sr; logic [31:0] g;
        send(2'd3, d, s, LEN_W'(n), 32'd0);
        wait_done(sr, g);
        model_copy(d, s, n);
    endtask

    task automatic verify_all(input string req);
        for (int i = 0; i < NW; i++) peek_chk(waddr(i), req);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NW; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(cmd_ready == 1'b1, "R10 cmd_ready", 32'(cmd_ready), 32'd1);
        check(rd_valid == 1'b0, "R10 rd_valid", 32'(rd_valid), 32'd0);
        check(done == 1'b0, "R10 done", 32'(done), 32'd0);
        peek_chk(16'h8005, "R10 reset word");

        // R1 write and readback across stages
        do_write(16'h0003, 32'hDEAD0001);
        do_write(16'h400F, 32'hBEEF0002);
        do_write(16'hC000, 32'hCAFE0003);
        peek_chk(16'h0003, "R1 stage0");
        peek_chk(16'h400F, "R1 stage1");
        peek_chk(16'hC000, "R1 stage3");

        // fill everything with random data
        for (int i = 0; i < NW; i++) do_write(waddr(i), $urandom);
        verify_all("R3 readback");

        // R8 kind 0 ignored in idle
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 2'd0; cmd_addr = 16'h0003; cmd_data = 32'h11111111;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R8 kind0 ignored", 32'(cmd_ready), 32'd1);
        cmd_valid = 1'b0;
        peek_chk(16'h0003, "R8 kind0 no write");

        // R6 basic copy across stages
        do_copy(16'h8000, 16'h0000, 16);
        verify_all("R6 copy");

        // R6 overlapping: destination inside source range
        do_copy(16'h4004, 16'h4000, 8);
        verify_all("R6 overlap snapshot");

        // R9 wrap past 0xFFFF into stage 0
        do_copy(16'h4008, 16'hFFFC, 6);
        verify_all("R9 wrap src");
        do_copy(16'hFFFE, 16'h8000, 4);
        verify_all("R9 wrap dst");

        // R7 zero length and over-long
        do_copy(16'h0000, 16'hC000, 0);
        verify_all("R7 zero length");
        do_copy(16'h0000, 16'hC000, 40);
        verify_all("R7 clamp");

        // R8 commands while busy are ignored
        begin
            logic sr; logic [31:0] g;
            send(2'd3, 16'h8000, 16'h4000, 6'd16, 32'd0);
            cmd_valid = 1'b1; cmd_kind = 2'd1; cmd_addr = 16'h0007; cmd_data = 32'h5A5A5A5A;
            repeat (3) begin
                @(negedge clk);
                check(cmd_ready == 1'b0, "R8 busy", 32'(cmd_ready), 32'd0);
            end
            cmd_valid = 1'b0; cmd_kind = 2'd0;
            wait_done(sr, g);
            model_copy(16'h8000, 16'h4000, 16);
            peek_chk(16'h0007, "R8 busy write ignored");
        end

        // random copies
        for (int r = 0; r < 40; r++) begin
            logic [15:0] s, d;
            int n;
            s = 16'($urandom); d = 16'($urandom); n = int'($urandom_range(0, 20));
            do_copy(d, s, n);
        end
        verify_all("R6 random copies");

        finish_run();
    end
endmodule